// File: doc/BRIEF.md
# I2C Bus Status and Interrupt Flag Register

This block holds the status byte of an I2C controller as the CPU sees it through an 8-bit register port. It synchronizes the raw SCL and SDA lines and finds start and stop conditions on them. From these it keeps a bus-busy flag. While the controller is master transmitter, it compares the levels the controller drives with the levels on the bus and records a lost arbitration.

It also holds the slave-address and general-call match flags and the acknowledge bit. It raises the interrupt request flag on the events that apply to the current mode and format. A CPU write that asks for a start or a stop condition becomes a single-cycle request pulse to the bus sequencer.

Event strobes come from the byte-transfer engine: end of transfer, own-address hit, general-call hit, acknowledge sample and data-register access. The CPU can clear a flag only by writing 0 to it after a read that returned it as 1.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset the register reads 0x30. That is: busy (bit 7) 0, interrupt request (bit 6) 0, start/stop inhibit (bit 5) 1, reserved (bit 4) 1, arbitration lost (bit 3) 0, slave address match (bit 2) 0, general call match (bit 1) 0, acknowledge (bit 0) 0. Both request pulses are low and the interrupt output is low.
- R2: Bit 7 becomes 1 after a start condition (SDA falls while SCL is high) and 0 after a stop condition (SDA rises while SCL is high), both seen on the synchronized lines.
- R3: Bit 5 always reads 1. A write with bit 5 = 0 produces a one-cycle request in the cycle after the write: `start_req` when bit 7 of the written byte is 1, `stop_req` when it is 0. A write with bit 5 = 1 produces neither.
- R4: The CPU clears bits 6, 3, 2 or 1 only by writing 0 to them after a read that returned that bit as 1. The read mark is dropped by the next register write. Writing 0 without a prior read, or writing 1, leaves the flag unchanged.
- R5: Bits 3, 2 and 1 clear on a data-register write while transmitting, or on a data-register read while receiving. The other kind of access leaves them unchanged.
- R6: In master transmit mode, bit 3 sets when the driven SDA differs from the synchronized bus SDA at a rising SCL edge. It stays 0 when the two agree.
- R7: In master transmit mode, bit 3 sets when the internally driven SCL is high at a falling edge of the synchronized bus SCL.
- R8: In slave receive mode, a general-call hit sets bits 1 and 2. An own-address hit sets bit 2 only.
- R9: In master mode, bit 6 sets at every end of transfer and when arbitration is lost.
- R10: In slave mode with `fmt_sel` = 0, bit 6 sets on an address or general-call hit. It sets again on each end of transfer until a start or a stop condition is seen. An end of transfer with no open match does not set it.
- R11: In slave mode with `fmt_sel` = 1, bit 6 sets on every end of transfer.
- R12: Bit 0 is written by the CPU and drives `ack_drv`. While transmitting, an `ack_strobe` loads bit 0 from `ack_rx`, where 0 means acknowledged and 1 means not acknowledged.
- R13: When a hardware set and a CPU clear of the same flag fall in one cycle, the flag ends up 1.
- R14: `irq` is high exactly when bit 6 is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Raw SCL bus level |
| sda_in | input | 1 | Raw SDA bus level |
| scl_drv | input | 1 | SCL level this controller drives (1 = released) |
| sda_drv | input | 1 | SDA level this controller drives (1 = released) |
| master | input | 1 | 1 = master mode |
| transmit | input | 1 | 1 = transmit mode |
| fmt_sel | input | 1 | Slave interrupt format select |
| xfer_done | input | 1 | End-of-transfer strobe |
| own_hit | input | 1 | Own slave address matched strobe |
| gc_hit | input | 1 | General call address matched strobe |
| ack_strobe | input | 1 | Acknowledge sample strobe |
| ack_rx | input | 1 | Acknowledge level received |
| dr_wr | input | 1 | Data register write strobe |
| dr_rd | input | 1 | Data register read strobe |
| stat_wr | input | 1 | Status register write |
| stat_rd | input | 1 | Status register read |
| stat_wdata | input | 8 | Write data |
| stat_rdata | output | 8 | Register contents |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| start_req | output | 1 | One-cycle start condition request |
| stop_req | output | 1 | One-cycle stop condition request |
| ack_drv | output | 1 | Level to drive in the acknowledge slot |

## Verification
The bench builds the block with three synchronizer stages instead of the default two, and with the SCL-fall arbitration check enabled. The extra stage shows that start, stop and arbitration detection depend only on the relative order of the synchronized samples, not on a fixed latency. Because the fall check is enabled, both kinds of arbitration loss can be exercised, along with the mode gating around them.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_BUSY  = 7;
    localparam int BIT_IRQ   = 6;
    localparam int BIT_NOSS  = 5;
    localparam int BIT_RSVD  = 4;
    localparam int BIT_ARB   = 3;
    localparam int BIT_SADR  = 2;
    localparam int BIT_GCALL = 1;
    localparam int BIT_ACK   = 0;

    typedef struct packed {
        logic busy;
        logic irq_flag;
        logic arb_lost;
        logic saddr;
        logic gcall;
        logic ack;
    } stat_flags_t;

    typedef struct packed {
        logic irq_flag;
        logic arb_lost;
        logic saddr;
        logic gcall;
    } rd_mark_t;

    function automatic logic [REG_W-1:0] pack_reg(input stat_flags_t f);
        logic [REG_W-1:0] r;
        r            = '0;
        r[BIT_BUSY]  = f.busy;
        r[BIT_IRQ]   = f.irq_flag;
        r[BIT_NOSS]  = 1'b1;
        r[BIT_RSVD]  = 1'b1;
        r[BIT_ARB]   = f.arb_lost;
        r[BIT_SADR]  = f.saddr;
        r[BIT_GCALL] = f.gcall;
        r[BIT_ACK]   = f.ack;
        return r;
    endfunction
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int SH_W = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [SH_W-1:0] scl_sh;
        logic [SH_W-1:0] sda_sh;
        logic            scl_p;
        logic            sda_p;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d        = mon_q;
        mon_d.scl_sh = {mon_q.scl_sh[SH_W-2:0], scl_in};
        mon_d.sda_sh = {mon_q.sda_sh[SH_W-2:0], sda_in};
        mon_d.scl_p  = mon_q.scl_sh[SH_W-1];
        mon_d.sda_p  = mon_q.sda_sh[SH_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '1;
        else        mon_q <= mon_d;
    end

    assign scl_s     = mon_q.scl_sh[SH_W-1];
    assign sda_s     = mon_q.sda_sh[SH_W-1];
    assign scl_rise  = scl_s & ~mon_q.scl_p;
    assign scl_fall  = ~scl_s & mon_q.scl_p;
    assign start_det = scl_s & mon_q.scl_p & mon_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & mon_q.scl_p & ~mon_q.sda_p & sda_s;

    p_cond_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));
endmodule

// File: rtl/i2c_arb_chk.sv
module i2c_arb_chk #(
    parameter bit ARB_ON_FALL = 1'b1
) (
    input  logic master,
    input  logic transmit,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_s,
    input  logic sda_drv,
    input  logic scl_drv,
    output logic al_evt
);
    logic rise_hit;
    logic fall_hit;

    assign rise_hit = scl_rise & (sda_drv ^ sda_s);

    generate
        if (ARB_ON_FALL) begin : g_fall
            assign fall_hit = scl_fall & scl_drv;
        end else begin : g_nofall
            assign fall_hit = 1'b0;
        end
    endgenerate

    assign al_evt = master & transmit & (rise_hit | fall_hit);
endmodule

// File: rtl/i2c_flag_core.sv
module i2c_flag_core
    import i2c_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             al_evt,
    input  logic             master,
    input  logic             transmit,
    input  logic             fmt_sel,
    input  logic             xfer_done,
    input  logic             own_hit,
    input  logic             gc_hit,
    input  logic             ack_strobe,
    input  logic             ack_rx,
    input  logic             dr_wr,
    input  logic             dr_rd,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [REG_W-1:0] cpu_wdata,
    output stat_flags_t      flags,
    output logic             start_req,
    output logic             stop_req
);
    typedef struct packed {
        stat_flags_t f;
        rd_mark_t    m;
        logic        win;
        logic        sreq;
        logic        preq;
    } core_t;

    core_t core_d, core_q;
    logic  slave_rx;
    logic  addr_evt;
    logic  dr_clr;
    logic  irq_set;

    always_comb begin
        core_d      = core_q;
        core_d.sreq = 1'b0;
        core_d.preq = 1'b0;

        slave_rx = ~master & ~transmit;
        addr_evt = slave_rx & (own_hit | gc_hit);
        dr_clr   = (dr_wr & transmit) | (dr_rd & ~transmit);

        if (master)       irq_set = xfer_done | al_evt;
        else if (fmt_sel) irq_set = xfer_done;
        else              irq_set = addr_evt | (xfer_done & core_q.win);

        // bus busy
        if (stop_det)  core_d.f.busy = 1'b0;
        if (start_det) core_d.f.busy = 1'b1;

        // read marks
        if (cpu_rd) begin
            if (core_q.f.irq_flag) core_d.m.irq_flag = 1'b1;
            if (core_q.f.arb_lost) core_d.m.arb_lost = 1'b1;
            if (core_q.f.saddr)    core_d.m.saddr    = 1'b1;
            if (core_q.f.gcall)    core_d.m.gcall    = 1'b1;
        end

        // CPU write: clears, requests, acknowledge bit
        if (cpu_wr) begin
            if (core_q.m.irq_flag && !cpu_wdata[BIT_IRQ])   core_d.f.irq_flag = 1'b0;
            if (core_q.m.arb_lost && !cpu_wdata[BIT_ARB])   core_d.f.arb_lost = 1'b0;
            if (core_q.m.saddr    && !cpu_wdata[BIT_SADR])  core_d.f.saddr    = 1'b0;
            if (core_q.m.gcall    && !cpu_wdata[BIT_GCALL]) core_d.f.gcall    = 1'b0;
            core_d.m = '0;
            if (!cpu_wdata[BIT_NOSS]) begin
                if (cpu_wdata[BIT_BUSY]) core_d.sreq = 1'b1;
                else                     core_d.preq = 1'b1;
            end
            core_d.f.ack = cpu_wdata[BIT_ACK];
        end

        // automatic clear on data register access
        if (dr_clr) begin
            core_d.f.arb_lost = 1'b0;
            core_d.f.saddr    = 1'b0;
            core_d.f.gcall    = 1'b0;
        end

        // slave match window (format 0)
        if (start_det || stop_det) core_d.win = 1'b0;
        if (addr_evt && !fmt_sel)  core_d.win = 1'b1;

        // hardware sets win over clears
        if (al_evt)             core_d.f.arb_lost = 1'b1;
        if (addr_evt)           core_d.f.saddr    = 1'b1;
        if (slave_rx && gc_hit) core_d.f.gcall    = 1'b1;
        if (irq_set)            core_d.f.irq_flag = 1'b1;
        if (ack_strobe && transmit) core_d.f.ack  = ack_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign flags     = core_q.f;
    assign start_req = core_q.sreq;
    assign stop_req  = core_q.preq;

    p_busy_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> core_q.f.busy);
    p_busy_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !core_q.f.busy);
    p_req_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_req && stop_req));
    p_req_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> $past(cpu_wr && !cpu_wdata[BIT_NOSS] && cpu_wdata[BIT_BUSY]));
    p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_q.f.irq_flag) |-> $past(cpu_wr && core_q.m.irq_flag));
    p_al_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.f.arb_lost) |-> $past(al_evt));
    p_gcall_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.f.gcall) |-> core_q.f.saddr);
    p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> core_q.f.irq_flag);
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
    import i2c_stat_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit ARB_ON_FALL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             scl_drv,
    input  logic             sda_drv,
    input  logic             master,
    input  logic             transmit,
    input  logic             fmt_sel,
    input  logic             xfer_done,
    input  logic             own_hit,
    input  logic             gc_hit,
    input  logic             ack_strobe,
    input  logic             ack_rx,
    input  logic             dr_wr,
    input  logic             dr_rd,
    input  logic             stat_wr,
    input  logic             stat_rd,
    input  logic [REG_W-1:0] stat_wdata,
    output logic [REG_W-1:0] stat_rdata,
    input  logic             irq_en,
    output logic             irq,
    output logic             start_req,
    output logic             stop_req,
    output logic             ack_drv
);
    logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic        al_evt;
    stat_flags_t flags;

    i2c_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_arb_chk #(.ARB_ON_FALL(ARB_ON_FALL)) u_arb (
        .master   (master),
        .transmit (transmit),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_s    (sda_s),
        .sda_drv  (sda_drv),
        .scl_drv  (scl_drv),
        .al_evt   (al_evt)
    );

    i2c_flag_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .al_evt     (al_evt),
        .master     (master),
        .transmit   (transmit),
        .fmt_sel    (fmt_sel),
        .xfer_done  (xfer_done),
        .own_hit    (own_hit),
        .gc_hit     (gc_hit),
        .ack_strobe (ack_strobe),
        .ack_rx     (ack_rx),
        .dr_wr      (dr_wr),
        .dr_rd      (dr_rd),
        .cpu_wr     (stat_wr),
        .cpu_rd     (stat_rd),
        .cpu_wdata  (stat_wdata),
        .flags      (flags),
        .start_req  (start_req),
        .stop_req   (stop_req)
    );

    assign stat_rdata = pack_reg(flags);
    assign irq        = flags.irq_flag & irq_en;
    assign ack_drv    = flags.ack;

    p_irq_gate_r14: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
    p_noss_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[BIT_NOSS] && stat_rdata[BIT_RSVD]);
endmodule

// File: tb/i2c_stat_reg_bench.sv
module i2c_stat_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1, scl_drv = 1'b1, sda_drv = 1'b1;
    logic       master = 1'b0, transmit = 1'b0, fmt_sel = 1'b0;
    logic       xfer_done = 1'b0, own_hit = 1'b0, gc_hit = 1'b0;
    logic       ack_strobe = 1'b0, ack_rx = 1'b0, dr_wr = 1'b0, dr_rd = 1'b0;
    logic       stat_wr = 1'b0, stat_rd = 1'b0;
    logic [7:0] stat_wdata = 8'h00;
    logic [7:0] stat_rdata;
    logic       irq_en = 1'b0;
    logic       irq, start_req, stop_req, ack_drv;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_stat_reg #(.SYNC_STAGES(3), .ARB_ON_FALL(1'b1)) u_i2c_stat_reg (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_drv(scl_drv), .sda_drv(sda_drv), .master(master), .transmit(transmit),
        .fmt_sel(fmt_sel), .xfer_done(xfer_done), .own_hit(own_hit), .gc_hit(gc_hit),
        .ack_strobe(ack_strobe), .ack_rx(ack_rx), .dr_wr(dr_wr), .dr_rd(dr_rd),
        .stat_wr(stat_wr), .stat_rd(stat_rd), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .irq_en(irq_en), .irq(irq),
        .start_req(start_req), .stop_req(stop_req), .ack_drv(ack_drv)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_read();
        stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [7:0] v);
        stat_wr = 1'b1; stat_wdata = v; cyc(1); stat_wr = 1'b0;
    endtask

    task automatic clear_all();
        cpu_read(); cpu_write(8'h20);
    endtask

    // 0 xfer_done, 1 own_hit, 2 gc_hit, 3 dr_wr, 4 dr_rd
    task automatic pulse(input int which);
        case (which)
            0: xfer_done = 1'b1;
            1: own_hit = 1'b1;
            2: gc_hit = 1'b1;
            3: dr_wr = 1'b1;
            default: dr_rd = 1'b1;
        endcase
        cyc(1);
        xfer_done = 1'b0; own_hit = 1'b0; gc_hit = 1'b0; dr_wr = 1'b0; dr_rd = 1'b0;
    endtask

    task automatic lines(input logic c, input logic d);
        scl_in = c; sda_in = d; cyc(8);
    endtask

    task automatic t_reset();
        chk("R1 rdata", stat_rdata, 8'h30);
        chk("R1 reqs", {6'b0, start_req, stop_req}, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_busy();
        lines(1'b1, 1'b0);
        chk("R2 busy after start", {7'b0, stat_rdata[7]}, 8'h01);
        lines(1'b1, 1'b1);
        chk("R2 busy after stop", {7'b0, stat_rdata[7]}, 8'h00);
    endtask

    task automatic t_reqs();
        cpu_write(8'h80);
        chk("R3 start pulse", {6'b0, start_req, stop_req}, 8'h02);
        cyc(1);
        chk("R3 one cycle", {6'b0, start_req, stop_req}, 8'h00);
        cpu_write(8'h00);
        chk("R3 stop pulse", {6'b0, start_req, stop_req}, 8'h01);
        cpu_write(8'hA0);
        chk("R3 inhibit set", {6'b0, start_req, stop_req}, 8'h00);
        chk("R3 bit5 reads 1", {7'b0, stat_rdata[5]}, 8'h01);
        cyc(1);
    endtask

    task automatic t_slave_flags();
        master = 1'b0; transmit = 1'b0; fmt_sel = 1'b0;
        pulse(2);
        chk("R8 gcall sets bits 2,1", {6'b0, stat_rdata[2:1]}, 8'h03);
        cpu_write(8'h20);
        chk("R4 no read no clear", {6'b0, stat_rdata[2:1]}, 8'h03);
        cpu_read();
        cpu_write(8'h6F);
        chk("R4 write 1 keeps", {6'b0, stat_rdata[2:1]}, 8'h03);
        cpu_read();
        cpu_write(8'h6D);
        chk("R4 clear gcall only", {6'b0, stat_rdata[2:1]}, 8'h02);
        clear_all();
        chk("R4 all cleared", {4'b0, stat_rdata[6], stat_rdata[3:1]}, 8'h00);
        pulse(1);
        chk("R8 own addr sets bit2 only", {6'b0, stat_rdata[2:1]}, 8'h02);
        pulse(3);
        chk("R5 dr_wr in rx keeps", {7'b0, stat_rdata[2]}, 8'h01);
        pulse(4);
        chk("R5 dr_rd in rx clears", {7'b0, stat_rdata[2]}, 8'h00);
        clear_all();
    endtask

    task automatic t_arb();
        master = 1'b1; transmit = 1'b1;
        scl_drv = 1'b0; lines(1'b0, 1'b1);
        sda_drv = 1'b1; lines(1'b0, 1'b0);
        chk("R6 no loss yet", {7'b0, stat_rdata[3]}, 8'h00);
        scl_drv = 1'b1; lines(1'b1, 1'b0);
        chk("R6 sda mismatch at rise", {7'b0, stat_rdata[3]}, 8'h01);
        chk("R9 irq on arb loss", {7'b0, stat_rdata[6]}, 8'h01);
        clear_all();
        sda_drv = 1'b0; scl_drv = 1'b0; lines(1'b0, 1'b0);
        scl_drv = 1'b1; lines(1'b1, 1'b0);
        chk("R6 match at rise no loss", {7'b0, stat_rdata[3]}, 8'h00);
        lines(1'b0, 1'b0);
        chk("R7 scl driven high at fall", {7'b0, stat_rdata[3]}, 8'h01);
        pulse(4);
        chk("R5 dr_rd in tx keeps", {7'b0, stat_rdata[3]}, 8'h01);
        pulse(3);
        chk("R5 dr_wr in tx clears", {7'b0, stat_rdata[3]}, 8'h00);
        master = 1'b0; sda_drv = 1'b1;
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        clear_all();
        master = 1'b1;
        transmit = 1'b0;
        pulse(0);
        chk("R9 irq on transfer end", {7'b0, stat_rdata[6]}, 8'h01);
        clear_all();
    endtask

    task automatic t_fmt0();
        master = 1'b0; transmit = 1'b0; fmt_sel = 1'b0;
        pulse(0);
        chk("R10 no match no irq", {7'b0, stat_rdata[6]}, 8'h00);
        pulse(1);
        chk("R10 irq on match", {7'b0, stat_rdata[6]}, 8'h01);
        clear_all();
        pulse(0);
        chk("R10 irq on transfer in window", {7'b0, stat_rdata[6]}, 8'h01);
        clear_all();
        lines(1'b1, 1'b0);
        lines(1'b1, 1'b1);
        pulse(0);
        chk("R10 window closed by stop", {7'b0, stat_rdata[6]}, 8'h00);
    endtask

    task automatic t_fmt1();
        fmt_sel = 1'b1;
        clear_all();
        pulse(0);
        chk("R11 irq each transfer", {7'b0, stat_rdata[6]}, 8'h01);
        clear_all();
        fmt_sel = 1'b0;
    endtask

    task automatic t_ack();
        master = 1'b0; transmit = 1'b0;
        cpu_write(8'h21);
        chk("R12 cpu ack bit", {6'b0, stat_rdata[0], ack_drv}, 8'h03);
        transmit = 1'b1;
        ack_rx = 1'b0; ack_strobe = 1'b1; cyc(1); ack_strobe = 1'b0;
        chk("R12 ack received", {7'b0, stat_rdata[0]}, 8'h00);
        ack_rx = 1'b1; ack_strobe = 1'b1; cyc(1); ack_strobe = 1'b0;
        chk("R12 nack received", {7'b0, stat_rdata[0]}, 8'h01);
        transmit = 1'b0;
        cpu_write(8'h20);
    endtask

    task automatic t_set_wins();
        master = 1'b1; transmit = 1'b0;
        pulse(0);
        cpu_read();
        stat_wr = 1'b1; stat_wdata = 8'h20; xfer_done = 1'b1;
        cyc(1);
        stat_wr = 1'b0; xfer_done = 1'b0;
        chk("R13 set wins over clear", {7'b0, stat_rdata[6]}, 8'h01);
        cpu_write(8'h20);
        chk("R4 mark dropped by write", {7'b0, stat_rdata[6]}, 8'h01);
    endtask

    task automatic t_irq();
        irq_en = 1'b0; cyc(1);
        chk("R14 masked", {7'b0, irq}, 8'h00);
        irq_en = 1'b1; cyc(1);
        chk("R14 enabled", {7'b0, irq}, 8'h01);
        clear_all(); cyc(1);
        chk("R14 flag cleared", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_busy();
        t_reqs();
        t_slave_flags();
        t_arb();
        t_fmt0();
        t_fmt1();
        t_ack();
        t_set_wins();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule